// File: doc/BRIEF.md
# SD Block DMA Engine

This engine copies one 512-byte data block from an SD card's 4-bit data bus straight into on-chip memory, so the controlling processor never touches the payload. The processor first reads the card's start bit itself. It then raises the enable line with a destination code and a window flag, and drops the line again. That falling edge starts the transfer.

The engine drives the SD clock and samples the four data lines on each rising edge. It joins nibble pairs into bytes and writes them through a byte port. The byte port serves three destinations, and each destination has its own base pointer. In window mode, only bytes whose block offset lies inside a programmed half-open range are written. The trailing CRC is clocked through and thrown away. The busy flag stays high for the whole transfer, and the processor polls it.

Top module: `sd_blk_dma`

## Requirements
- R1: A falling edge of `dma_en` while idle raises `busy` on the next clock. `busy` stays high for exactly 2·(1024+16) = 2080 clocks and then drops.
- R2: While idle, `sd_clk` is low. While busy, `sd_clk` toggles on every clock, giving one SD clock per two system clocks. `sd_dat` is sampled when `sd_clk` rises.
- R3: The first nibble of each pair is the high half of the byte: byte k = {nibble 2k, nibble 2k+1}.
- R4: In full mode (`dma_part`=0) all 512 bytes are written in offset order. The addresses run consecutively, starting at the selected base pointer.
- R5: `dma_tgt` selects the destination: 0 writes through `mem_we[0]` from `ptr_ram`, 1 through `mem_we[1]` from `ptr_aud`, and 2 through `mem_we[2]` from `ptr_dat`. Code 3 writes nothing. At most one strobe is high, and writes are never on back-to-back clocks.
- R6: In window mode (`dma_part`=1) only offsets o with `win_start` ≤ o < `win_end` are written. The first byte written goes to the base pointer, and the address increments only on written bytes.
- R7: A window with `win_start` ≥ `win_end`, or one lying wholly past offset 511, writes nothing, yet the transfer keeps its full length.
- R8: Toggling `dma_en` or changing `dma_tgt`/`dma_part` while busy has no effect on the transfer in progress.
- R9: The 16 CRC clocks after the 1024 data nibbles produce no writes.
- R10: After reset, `busy`, `sd_clk` and `mem_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Start strobe; its falling edge launches a transfer |
| dma_tgt | input | 2 | Destination code, captured while `dma_en` is high |
| dma_part | input | 1 | Window-mode flag, captured while `dma_en` is high |
| win_start | input | 16 | First block offset kept in window mode |
| win_end | input | 16 | Offset one past the last one kept |
| ptr_ram | input | AW | Base address for destination 0 |
| ptr_aud | input | AW | Base address for destination 1 |
| ptr_dat | input | AW | Base address for destination 2 |
| sd_clk | output | 1 | SD clock driven to the card |
| sd_dat | input | 4 | SD data lines |
| mem_addr | output | AW | Write address |
| mem_data | output | 8 | Write data |
| mem_we | output | 3 | One-hot write strobe per destination |
| busy | output | 1 | High while a block is in flight |

## Verification
Full-block transfers to each destination code separate the strobe routing and base selection from the nibble ordering. Random nibbles make a swapped half-byte visible at every offset. Windows are placed at the block start, in the middle, straddling offset 511, and in an empty or inverted configuration. These cases separate a bad comparison bound from a bad address increment, and they show that the transfer length does not depend on how many bytes are kept. A retrigger with a different code in mid-block shows that the captured fields are frozen. Randomised windows and pointers cover the remaining combinations.

// File: rtl/sd_blk_dma.sv
module sd_blk_dma #(
  parameter int AW        = 16,
  parameter int BLK_BYTES = 512,
  parameter int CRC_CLKS  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic [1:0]    dma_tgt,
  input  logic          dma_part,
  input  logic [15:0]   win_start,
  input  logic [15:0]   win_end,
  input  logic [AW-1:0] ptr_ram,
  input  logic [AW-1:0] ptr_aud,
  input  logic [AW-1:0] ptr_dat,
  output logic          sd_clk,
  input  logic [3:0]    sd_dat,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic [2:0]    mem_we,
  output logic          busy
);
  localparam int DATA_NIB = BLK_BYTES * 2;
  localparam int TOTAL    = DATA_NIB + CRC_CLKS;
  localparam int CW       = $clog2(TOTAL + 1);

  logic          en_q, part_q;
  logic [1:0]    tgt_q;
  logic [15:0]   lo_q, hi_lim_q;
  logic [CW-1:0] cnt;
  logic [3:0]    hi_nib;
  logic [AW-1:0] waddr, base;

  always_ff @(posedge clk) en_q <= dma_en;

  wire        start   = en_q & ~dma_en & ~busy;
  wire        rise    = busy & ~sd_clk;
  wire [15:0] off     = 16'(cnt >> 1);
  wire        in_data = cnt < CW'(DATA_NIB);
  wire        keep    = ~part_q | (off >= lo_q && off < hi_lim_q);
  wire [2:0]  tgt_hot = (tgt_q == 2'd3) ? 3'b000 : 3'(1 << tgt_q);

  always_comb
    case (tgt_q)
      2'd1:    base = ptr_aud;
      2'd2:    base = ptr_dat;
      default: base = ptr_ram;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; sd_clk <= 1'b0; mem_we <= 3'b000; mem_addr <= '0;
      mem_data <= 8'h00; tgt_q <= 2'd0; part_q <= 1'b0; lo_q <= 16'h0;
      hi_lim_q <= 16'h0; cnt <= '0; hi_nib <= 4'h0; waddr <= '0;
    end else begin
      mem_we <= 3'b000;
      if (!busy) begin
        if (dma_en) begin
          tgt_q  <= dma_tgt;
          part_q <= dma_part;
        end
        if (start) begin
          busy     <= 1'b1;
          sd_clk   <= 1'b0;
          cnt      <= '0;
          lo_q     <= win_start;
          hi_lim_q <= win_end;
          waddr    <= base;
        end
      end else begin
        sd_clk <= ~sd_clk;
        if (rise) begin
          cnt <= cnt + 1'b1;
          if (in_data) begin
            if (!cnt[0]) hi_nib <= sd_dat;
            else if (keep) begin
              mem_we   <= tgt_hot;
              mem_data <= {hi_nib, sd_dat};
              mem_addr <= waddr;
              waddr    <= waddr + 1'b1;
            end
          end
        end else if (cnt == CW'(TOTAL)) begin
          busy <= 1'b0;
        end
      end
    end
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dma_en) && !busy) |=> busy);
  assert_clk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sd_clk);
  assert_clk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (sd_clk != $past(sd_clk)));
  assert_one_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_we));
  assert_write_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != 3'b000) |=> (mem_we == 3'b000));
  assert_write_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != 3'b000) |-> $past(busy));
endmodule

// File: tb/sd_blk_dma_tb.sv
module sd_blk_dma_tb;
  localparam int AW = 16;
  localparam int NNIB = 1040;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_en = 1'b0, dma_part = 1'b0;
  logic [1:0] dma_tgt = 2'd0;
  logic [15:0] win_start = 16'h0, win_end = 16'h0;
  logic [AW-1:0] ptr_ram = '0, ptr_aud = '0, ptr_dat = '0;
  logic sd_clk, busy;
  logic [3:0] sd_dat = 4'h0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic [2:0] mem_we;

  always #4 clk = ~clk;

  sd_blk_dma #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dma_tgt(dma_tgt),
    .dma_part(dma_part), .win_start(win_start), .win_end(win_end),
    .ptr_ram(ptr_ram), .ptr_aud(ptr_aud), .ptr_dat(ptr_dat),
    .sd_clk(sd_clk), .sd_dat(sd_dat), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_we(mem_we), .busy(busy));

  int checks = 0, fails = 0;
  logic [3:0] nib [NNIB];
  logic [AW-1:0] exp_addr [512];
  logic [7:0] exp_data [512];
  logic [2:0] exp_we;
  int exp_n = 0, got_n = 0, idx = 0;
  bit pres = 1'b0;
  string cur_req = "R4";

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [AW-1:0] base_of(input logic [1:0] t);
    case (t)
      2'd1: return ptr_aud;
      2'd2: return ptr_dat;
      default: return ptr_ram;
    endcase
  endfunction

  task automatic build_expect(input logic [1:0] t, input bit part,
                              input logic [15:0] s, input logic [15:0] e);
    exp_n = 0;
    exp_we = (t == 2'd3) ? 3'b000 : 3'(1 << t);
    for (int o = 0; o < 512; o++) begin
      if (t != 2'd3 && (!part || (o >= s && o < e))) begin
        exp_addr[exp_n] = base_of(t) + AW'(exp_n);
        exp_data[exp_n] = {nib[2*o], nib[2*o+1]};
        exp_n++;
      end
    end
  endtask

  always @(negedge clk) begin
    if (busy && !sd_clk && !pres) begin
      sd_dat = (idx < NNIB) ? nib[idx] : 4'h0;
      pres = 1'b1;
    end else if (sd_clk && pres) begin
      idx++;
      pres = 1'b0;
    end
    if (mem_we != 3'b000) begin
      if (got_n < exp_n) begin
        chk(mem_we == exp_we, {cur_req, " R5 strobe"}, mem_we, exp_we);
        chk(mem_addr == exp_addr[got_n], {cur_req, " addr"}, mem_addr, exp_addr[got_n]);
        chk(mem_data == exp_data[got_n], {cur_req, " R3 data"}, mem_data, exp_data[got_n]);
      end else begin
        chk(1'b0, {cur_req, " R9 extra write"}, got_n, exp_n);
      end
      got_n++;
    end
  end

  task automatic xfer(input logic [1:0] t, input bit part, input logic [15:0] s,
                      input logic [15:0] e, input bit retrig, input string req);
    int bc;
    for (int i = 0; i < NNIB; i++) nib[i] = 4'($urandom);
    ptr_ram = AW'($urandom); ptr_aud = AW'($urandom); ptr_dat = AW'($urandom);
    cur_req = req;
    build_expect(t, part, s, e);
    got_n = 0; idx = 0; pres = 1'b0;
    @(negedge clk);
    dma_tgt = t; dma_part = part; win_start = s; win_end = e; dma_en = 1'b1;
    repeat (3) @(negedge clk);
    dma_en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after falling edge", busy, 1);
    bc = 1;
    while (1) begin
      @(negedge clk);
      if (!busy) break;
      bc++;
      if (retrig && bc == 100) begin
        dma_tgt = ~t; dma_part = ~part; win_start = 16'd0; win_end = 16'd1; dma_en = 1'b1;
      end
      if (retrig && bc == 103) dma_en = 1'b0;
      if (bc > 5000) break;
    end
    chk(bc == 2080, {req, " R1 busy length"}, bc, 2080);
    chk(!sd_clk, "R2 clock idle after transfer", sd_clk, 0);
    chk(got_n == exp_n, {req, " write count"}, got_n, exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(!busy, "R10 busy reset", busy, 0);
    chk(!sd_clk, "R10 sd_clk reset", sd_clk, 0);
    chk(mem_we == 3'b000, "R10 mem_we reset", mem_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sd_clk && !busy, "R2 idle clock low", sd_clk, 0);
    xfer(2'd0, 1'b0, 16'd0, 16'd0, 1'b0, "R4 R9 full ram");
    xfer(2'd1, 1'b0, 16'd0, 16'd0, 1'b0, "R5 full audio");
    xfer(2'd2, 1'b0, 16'd0, 16'd0, 1'b0, "R5 full data");
    xfer(2'd3, 1'b0, 16'd0, 16'd0, 1'b0, "R5 code 3");
    xfer(2'd0, 1'b1, 16'd10, 16'd20, 1'b0, "R6 mid window");
    xfer(2'd2, 1'b1, 16'd0, 16'd1, 1'b0, "R6 first byte");
    xfer(2'd1, 1'b1, 16'd500, 16'd600, 1'b0, "R6 tail window");
    xfer(2'd1, 1'b1, 16'd0, 16'd512, 1'b0, "R6 whole window");
    xfer(2'd0, 1'b1, 16'd30, 16'd30, 1'b0, "R7 empty window");
    xfer(2'd2, 1'b1, 16'd40, 16'd5, 1'b0, "R7 inverted window");
    xfer(2'd0, 1'b1, 16'd700, 16'd900, 1'b0, "R7 window past block");
    xfer(2'd1, 1'b0, 16'd0, 16'd0, 1'b1, "R8 retrigger ignored");
    for (int k = 0; k < 6; k++) begin
      logic [15:0] a, b;
      a = 16'($urandom_range(0, 600));
      b = 16'($urandom_range(0, 600));
      xfer(2'($urandom_range(0, 2)), 1'($urandom), a, b, 1'b0, "R6 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule